// File: doc/BRIEF.md
# Three-Axis Linear Step Interpolator

This block spreads step pulses over three axes so that a straight-line move from a start point to an end point reaches every axis target at the same moment. Each axis runs a digital integrator: a function register holds the axis move length, and an accumulator adds that length once per unit cycle. A carry out of the accumulator is one step for that axis. All three integrators share one accumulation counter, so every axis finishes on the same unit cycle and its pulses are spread evenly over the move.

A controller places signed start and end coordinates on the position buses and pulses `start_i`. A three-state sequencer moves from idle to run and then to done. Direction levels are settled before the first step. The move ends after exactly 2^ACC_W accumulations. `unit_en_i` is the rate input: an accumulation happens only on a clock where it is high, so the feed rate is the rate of enable pulses. Each axis length |end - start| must be below 2^ACC_W.

Top module: `dda_interp3`

## Requirements
- R1: After reset, `step_o`, `dir_o`, `busy_o` and `done_o` are all 0.
- R2: A move emits exactly |end - start| step clocks on each axis. For example, a move from (0,0,0) to (8,15,11) gives 8, 15 and 11 steps. Axis X is bit 0 of `step_o`/`dir_o` and bits [COORD_W-1:0] of the position buses, Y is next and Z is highest.
- R3: `dir_o` of an axis is 1 when end >= start and 0 otherwise. It is valid in the first cycle `busy_o` is high, and no step appears in that cycle. It holds through the move to done.
- R4: With `unit_en_i` held high, `busy_o` stays high for exactly 2^ACC_W cycles after the clock that accepts start.
- R5: `done_o` is high for exactly one cycle right after the busy period. In the next cycle `busy_o` and `done_o` are both 0.
- R6: `start_i` is accepted only when idle. A start pulse during a move changes neither the step counts, the directions nor the duration of that move.
- R7: Accumulation and progress happen only on clocks where `unit_en_i` is high. With the enable low, no new step appears and the move lasts longer by one cycle for each disabled cycle. The step totals stay the same.
- R8: Each step is high for one clock, in the cycle after the accumulation that carried. Steps appear only while busy or in the done cycle. An axis whose length is at most 2^(ACC_W-1) never steps in two consecutive cycles.
- R9: An axis with equal start and end emits no step and reports direction 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a move (taken only when idle) |
| unit_en_i | input | 1 | Unit-cycle enable; one accumulation per high clock |
| start_pos_i | input | 3*COORD_W | Signed start coordinates {Z,Y,X} |
| end_pos_i | input | 3*COORD_W | Signed end coordinates {Z,Y,X} |
| step_o | output | 3 | Step pulse per axis {Z,Y,X} |
| dir_o | output | 3 | Direction per axis, 1 = end >= start |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle move completion |

## Verification
The bench drives a move with mixed-sign, zero-length and maximum-length axes. An integrator that dropped the last carry, or a counter off by one, would miss a step or shorten the busy window. It gates the enable in two ways, alternating and a long initial stall, to catch a design that keeps accumulating or counting while disabled. That fault would show as early steps or a short move. A start pulse fired in the middle of a move exposes a sequencer that reloads its registers. A length of half the range checks that pulses stay evenly spread and never run together.

// File: rtl/dda_pkg.sv
package dda_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dda_state_e;
endpackage

// File: rtl/dda_seq.sv
module dda_seq
  import dda_pkg::*;
#(
  parameter int ACC_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  output logic load_o,
  output logic acc_en_o,
  output logic busy_o,
  output logic done_o
);
  dda_state_e       state_q;
  logic [ACC_W-1:0] cnt_q;
  logic             last_w;

  assign last_w = (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: if (en_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_w) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign acc_en_o = (state_q == ST_RUN) && en_i;
  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);

  // R5
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R6
  run_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R7
  hold_when_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> $stable(cnt_q) && busy_o);
endmodule

// File: rtl/dda_axis.sv
module dda_axis #(
  parameter int COORD_W = 8,
  parameter int ACC_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               acc_en_i,
  input  logic [COORD_W-1:0] start_c_i,
  input  logic [COORD_W-1:0] end_c_i,
  output logic               step_o,
  output logic               dir_o
);
  logic signed [COORD_W:0] diff_w;
  logic [ACC_W-1:0]        func_d, func_q, acc_q;
  logic [ACC_W:0]          sum_w;
  logic                    step_q, dir_q;

  // sign-extend both, subtract at one extra bit
  assign diff_w = $signed({end_c_i[COORD_W-1], end_c_i})
                - $signed({start_c_i[COORD_W-1], start_c_i});
  assign func_d = ACC_W'(diff_w[COORD_W] ? -diff_w : diff_w);
  assign sum_w  = {1'b0, acc_q} + {1'b0, func_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q <= '0;
      acc_q  <= '0;
      step_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (load_i) begin
      func_q <= func_d;
      acc_q  <= '0;
      step_q <= 1'b0;
      dir_q  <= ~diff_w[COORD_W];
    end else begin
      step_q <= acc_en_i & sum_w[ACC_W];
      if (acc_en_i) acc_q <= sum_w[ACC_W-1:0];
    end
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;

  // R8
  step_after_accum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(acc_en_i));

  // R3
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $stable(dir_o));
endmodule

// File: rtl/dda_interp3.sv
module dda_interp3 #(
  parameter int COORD_W  = 8,
  parameter int ACC_W    = 5,
  parameter int NUM_AXES = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        unit_en_i,
  input  logic [NUM_AXES*COORD_W-1:0] start_pos_i,
  input  logic [NUM_AXES*COORD_W-1:0] end_pos_i,
  output logic [NUM_AXES-1:0]         step_o,
  output logic [NUM_AXES-1:0]         dir_o,
  output logic                        busy_o,
  output logic                        done_o
);
  logic load_w, acc_en_w;

  dda_seq #(.ACC_W(ACC_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .en_i     (unit_en_i),
    .load_o   (load_w),
    .acc_en_o (acc_en_w),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    dda_axis #(.COORD_W(COORD_W), .ACC_W(ACC_W)) u_axis (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_w),
      .acc_en_i  (acc_en_w),
      .start_c_i (start_pos_i[g*COORD_W +: COORD_W]),
      .end_c_i   (end_pos_i[g*COORD_W +: COORD_W]),
      .step_o    (step_o[g]),
      .dir_o     (dir_o[g])
    );
  end

  // R8
  step_in_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != '0) |-> (busy_o || done_o));

  // R5
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/dda_interp3_bench.sv
`timescale 1ns/1ps
module dda_interp3_bench;
  localparam int CW = 8;
  localparam int AW = 5;
  localparam int NA = 3;
  localparam int SPAN = 1 << AW;

  typedef struct packed {
    logic [NA-1:0][7:0] cnt;
    logic [NA-1:0]      dir;
    logic [NA-1:0]      sparse;
    logic [15:0]        busy;
    logic [15:0]        quiet;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, unit_en_i = 1'b0;
  logic [NA*CW-1:0] start_pos_i = '0, end_pos_i = '0;
  logic [NA-1:0] step_o, dir_o;
  logic busy_o, done_o;

  int checks = 0, fails = 0;
  exp_t q[$];
  bit mon_on = 0;

  always #4 clk_i = ~clk_i;

  dda_interp3 #(.COORD_W(CW), .ACC_W(AW), .NUM_AXES(NA)) u_dda_interp3 (
    .clk_i, .rst_ni, .start_i, .unit_en_i, .start_pos_i, .end_pos_i,
    .step_o, .dir_o, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor
  bit in_move = 0, post_done = 0;
  int idx;
  int cnts[NA];
  bit consec[NA];
  logic [NA-1:0] prev, dir_first;
  exp_t cur;

  always @(negedge clk_i) if (mon_on) begin
    if (post_done) begin
      post_done = 0;
      chk(!busy_o && !done_o, "R5 idle after done", {busy_o, done_o}, 0);
    end
    if (!in_move) begin
      if (busy_o && q.size() > 0) begin
        in_move = 1; idx = 0; prev = '0; dir_first = dir_o; cur = q[0];
        for (int a = 0; a < NA; a++) begin cnts[a] = 0; consec[a] = 0; end
      end else if (step_o != '0) begin
        chk(0, "R8 step outside move", step_o, 0);
      end
    end
    if (in_move) begin
      if (busy_o) idx++;
      if (busy_o && idx <= cur.quiet && step_o != '0)
        chk(0, (cur.quiet > 1) ? "R7 step while gated" : "R3 step in first cycle", step_o, 0);
      for (int a = 0; a < NA; a++) begin
        if (step_o[a]) cnts[a]++;
        if (step_o[a] && prev[a]) consec[a] = 1;
      end
      prev = step_o;
      if (done_o) begin
        void'(q.pop_front());
        for (int a = 0; a < NA; a++) begin
          chk(cnts[a] == int'(cur.cnt[a]), $sformatf("R2 step count axis %0d", a), cnts[a], cur.cnt[a]);
          if (cur.sparse[a])
            chk(!consec[a], $sformatf("R8 spread axis %0d", a), consec[a], 0);
        end
        chk(dir_first == cur.dir, "R3 dir at first busy cycle", dir_first, cur.dir);
        chk(dir_o == cur.dir, "R3 dir held to done", dir_o, cur.dir);
        chk(idx == int'(cur.busy), "R4 busy length", idx, cur.busy);
        in_move = 0;
        post_done = 1;
      end
    end
  end

  // driver: mode 0 enable always, 1 alternating, 2 stalled for stall cycles
  task automatic do_move(input int s[NA], input int e[NA], input int mode, input int stall,
                         input bit spurious);
    exp_t x;
    int k;
    x = '0;
    for (int a = 0; a < NA; a++) begin
      int d;
      d = e[a] - s[a];
      x.cnt[a] = 8'((d < 0) ? -d : d);
      x.dir[a] = (d >= 0);
      x.sparse[a] = (((d < 0) ? -d : d) <= SPAN / 2);
      start_pos_i[a*CW +: CW] = CW'(s[a]);
      end_pos_i[a*CW +: CW] = CW'(e[a]);
    end
    x.busy  = 16'((mode == 0) ? SPAN : (mode == 1) ? 2 * SPAN : SPAN + stall);
    x.quiet = 16'((mode == 2) ? stall + 1 : 1);
    q.push_back(x);
    @(negedge clk_i);
    start_i = 1'b1;
    unit_en_i = 1'b0;
    k = 0;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) break;
      k++;
      case (mode)
        0: unit_en_i = 1'b1;
        1: unit_en_i = (k % 2 == 0);
        default: unit_en_i = (k > stall);
      endcase
      if (spurious && k == 5) begin
        start_i = 1'b1;
        start_pos_i = '0;
        end_pos_i = {8'd1, 8'd1, 8'd1};
      end
    end
    unit_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(step_o == 0 && dir_o == 0 && !busy_o && !done_o, "R1 reset state",
        {step_o, dir_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(step_o == 0 && dir_o == 0 && !busy_o && !done_o, "R1 after release",
        {step_o, dir_o, busy_o, done_o}, 0);
    mon_on = 1;
    // R2 R4 reference move
    do_move('{0, 0, 0}, '{8, 15, 11}, 0, 0, 0);
    // R7 R9 alternating enable, zero-length Y, negative X
    do_move('{10, -3, 5}, '{2, -3, 20}, 1, 0, 0);
    // R6 R8 spurious start, half-range and full-range axes
    do_move('{0, 0, 0}, '{16, 31, -31}, 0, 0, 1);
    // R7 long initial stall
    do_move('{-5, -5, -5}, '{5, 0, -20}, 2, 10, 0);
    repeat (3) @(negedge clk_i);
    chk(q.size() == 0, "R5 all moves completed", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule